// File: doc/BRIEF.md
# Masked Vector Execution Unit

This unit runs one element-wise vector command at a time against an external vector register file, under control of an internal per-element mask. Compare commands rebuild the mask from the elements of one or two source vectors. A complement command flips the mask within the active length. Arithmetic and move commands write a result element only where the mask bit is set, and the unit leaves every other destination element untouched.

Each arithmetic or move command runs in one of two modes. In the all-elements mode the unit steps through every element below the active length and holds back the write where the mask is clear. In the skip mode a find-next-set-bit scanner jumps straight from one enabled element to the next, so a sparse mask costs only as many cycles as it has set bits. The register file is read combinationally through two read ports that share an element index, and is written through one write port. A select of two vectors is built from a compare, a masked move, a complement and a second masked move.

Top module: `mvx_unit`

## Requirements
- R1: After reset, busy, done and wr_en are low and vmask is all zeros.
- R2: A command is taken when cmd_valid is high at a rising edge while busy is low. While busy is high, cmd_valid is ignored. Op code 7 is a no-op: it changes neither the mask nor any register and keeps busy high for one cycle.
- R3: Op codes 3, 4 and 5 set vmask[i], for each i below cmd_vlen, to (A[i]==0), (A[i]!=0) and (A[i]>=B[i]) respectively, with unsigned compare. They clear every bit at or above cmd_vlen.
- R4: Op code 6 inverts vmask[i] for i below cmd_vlen and clears the bits at or above it. Busy stays high for exactly one cycle, which is also the done cycle.
- R5: Op codes 0 (A+B), 1 (A-B) and 2 (A) write element i of the destination register, modulo 2^EW, only for i below cmd_vlen with vmask[i] set. All other destination elements keep their value, and the mask does not change.
- R6: When cmd_dense is 0, an arithmetic or move command keeps busy high for cmd_vlen+1 cycles. Done is high only in the last of those cycles.
- R7: When cmd_dense is 1, an arithmetic or move command writes the enabled elements in ascending index order. It keeps busy high for (number of set mask bits below cmd_vlen)+1 cycles, which is one cycle when none are set.
- R8: Compare commands take cmd_vlen+1 busy cycles whatever the value of cmd_dense.
- R9: With cmd_vlen of 0, an arithmetic command writes nothing and keeps busy high for one cycle in either mode.
- R10: The sequence compare-greater-or-equal(A,B), move A to C, complement, move B to C leaves C holding the element-wise unsigned maximum of A and B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Op code: 0 add, 1 sub, 2 move, 3 eq-zero, 4 ne-zero, 5 greater-or-equal, 6 complement, 7 no-op |
| cmd_dense | input | 1 | 1 selects the skip mode for arithmetic and move |
| cmd_vlen | input | $clog2(NELEM+1) | Active length in elements |
| cmd_src_a | input | $clog2(NREG) | Source register A |
| cmd_src_b | input | $clog2(NREG) | Source register B |
| cmd_dst | input | $clog2(NREG) | Destination register |
| busy | output | 1 | A command is in progress |
| done | output | 1 | Last cycle of a command |
| rd_reg_a | output | $clog2(NREG) | Read port A register select |
| rd_reg_b | output | $clog2(NREG) | Read port B register select |
| rd_elem | output | $clog2(NELEM) | Element index shared by both read ports |
| rd_data_a | input | EW | Read data A |
| rd_data_b | input | EW | Read data B |
| wr_en | output | 1 | Write strobe |
| wr_reg | output | $clog2(NREG) | Write register select |
| wr_elem | output | $clog2(NELEM) | Write element index |
| wr_data | output | EW | Write data |
| vmask | output | NELEM | Current mask |

## Verification
The assertions check several rules on every cycle. Skip-mode steps land only on set mask bits. The element index only rises within a command. Writes never reach past the active length. The mask holds still during arithmetic. A compare ends with no bits above the length, and done lasts a single cycle. Only the bench scenarios can show the rest: the actual result values, the preservation of disabled elements, the exact busy-cycle counts for each mode and length, that a command offered while busy is ignored, and the max-select idiom built from four commands.

// File: rtl/mvx_pkg.sv
package mvx_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_MOV  = 3'd2,
    OP_CEQZ = 3'd3,
    OP_CNEZ = 3'd4,
    OP_CGE  = 3'd5,
    OP_MNOT = 3'd6,
    OP_NOP  = 3'd7
  } mvx_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } mvx_state_e;

  function automatic logic is_cmp(input mvx_op_e op);
    return (op == OP_CEQZ) || (op == OP_CNEZ) || (op == OP_CGE);
  endfunction

  function automatic logic is_arith(input mvx_op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_MOV);
  endfunction

endpackage

// File: rtl/mvx_scan.sv
// Finds the lowest set bit of vec at or above position from.
module mvx_scan #(
  parameter int N  = 8,
  parameter int IW = 3,
  parameter int PW = 4
) (
  input  logic [N-1:0]  vec,
  input  logic [PW-1:0] from,
  output logic          found,
  output logic [IW-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i] && (i >= int'(from))) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

endmodule

// File: rtl/mvx_alu.sv
module mvx_alu
  import mvx_pkg::*;
#(
  parameter int EW = 16
) (
  input  mvx_op_e       op,
  input  logic [EW-1:0] a,
  input  logic [EW-1:0] b,
  output logic [EW-1:0] res,
  output logic          cmp_bit
);

  always_comb begin
    res     = '0;
    cmp_bit = 1'b0;
    case (op)
      OP_ADD:  res = a + b;
      OP_SUB:  res = a - b;
      OP_MOV:  res = a;
      OP_CEQZ: cmp_bit = (a == '0);
      OP_CNEZ: cmp_bit = (a != '0);
      OP_CGE:  cmp_bit = (a >= b);
      default: ;
    endcase
  end

endmodule

// File: rtl/mvx_seq.sv
module mvx_seq
  import mvx_pkg::*;
#(
  parameter int N  = 8,
  parameter int RW = 2,
  parameter int LW = 4,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic          cmd_dense,
  input  logic [LW-1:0] cmd_vlen,
  input  logic [RW-1:0] cmd_src_a,
  input  logic [RW-1:0] cmd_src_b,
  input  logic [RW-1:0] cmd_dst,
  input  logic          cmp_bit,
  output mvx_op_e       op_q,
  output logic [RW-1:0] src_a_q,
  output logic [RW-1:0] src_b_q,
  output logic [RW-1:0] dst_q,
  output logic [IW-1:0] idx_q,
  output logic [N-1:0]  mask_q,
  output logic          wr_en,
  output logic          busy,
  output logic          done
);

  localparam int PW = IW + 1;

  mvx_state_e    state_q, state_d;
  logic          dense_q;
  logic [LW-1:0] vlen_q;
  logic [IW-1:0] idx_d;
  logic [N-1:0]  mask_d;
  mvx_op_e       new_op;
  logic          idle, accept;
  logic [N-1:0]  len_new, len_cur;
  logic          scan_dense;
  logic [N-1:0]  scan_vec;
  logic [PW-1:0] scan_from;
  logic          scan_found;
  logic [IW-1:0] scan_idx;

  assign new_op = mvx_op_e'(cmd_op);
  assign idle   = (state_q == ST_IDLE);
  assign accept = cmd_valid && idle;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      len_new[i] = (i < int'(cmd_vlen));
      len_cur[i] = (i < int'(vlen_q));
    end
  end

  // One scanner serves both modes: all-ones mask for stepping, live mask for skipping.
  assign scan_dense = idle ? (cmd_dense && is_arith(new_op)) : (dense_q && is_arith(op_q));
  assign scan_vec   = (idle ? len_new : len_cur) & (scan_dense ? mask_q : {N{1'b1}});
  assign scan_from  = idle ? '0 : (PW'(idx_q) + PW'(1));

  mvx_scan #(.N(N), .IW(IW), .PW(PW)) u_scan (
    .vec   (scan_vec),
    .from  (scan_from),
    .found (scan_found),
    .idx   (scan_idx)
  );

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    mask_d  = mask_q;
    case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          case (new_op)
            OP_CEQZ, OP_CNEZ, OP_CGE, OP_ADD, OP_SUB, OP_MOV: begin
              if (is_cmp(new_op)) mask_d = '0;
              if (scan_found) begin
                state_d = ST_RUN;
                idx_d   = scan_idx;
              end else begin
                state_d = ST_FIN;
              end
            end
            OP_MNOT: begin
              mask_d  = ~mask_q & len_new;
              state_d = ST_FIN;
            end
            default: state_d = ST_FIN;
          endcase
        end
      end
      ST_RUN: begin
        if (is_cmp(op_q)) mask_d[idx_q] = cmp_bit;
        if (scan_found) idx_d = scan_idx;
        else            state_d = ST_FIN;
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      mask_q  <= '0;
      op_q    <= OP_NOP;
      dense_q <= 1'b0;
      vlen_q  <= '0;
      src_a_q <= '0;
      src_b_q <= '0;
      dst_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      mask_q  <= mask_d;
      if (accept) begin
        op_q    <= new_op;
        dense_q <= cmd_dense;
        vlen_q  <= cmd_vlen;
        src_a_q <= cmd_src_a;
        src_b_q <= cmd_src_b;
        dst_q   <= cmd_dst;
      end
    end
  end

  assign wr_en = (state_q == ST_RUN) && is_arith(op_q) && mask_q[idx_q];
  assign busy  = !idle;
  assign done  = (state_q == ST_FIN);

  // R5: a write never reaches past the active length
  p_wr_in_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(idx_q) < int'(vlen_q)));

  // R5: mask is left alone while arithmetic runs
  p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && is_arith(op_q)) |=> $stable(mask_q));

  // R7: skip mode only visits set mask bits
  p_dense_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && dense_q && is_arith(op_q)) |-> mask_q[idx_q]);

  // R7: element index rises strictly within a command
  p_idx_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |=> (state_q != ST_RUN || idx_q > $past(idx_q)));

  // R3: compare leaves no mask bits at or above the length
  p_cmp_tail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FIN && is_cmp(op_q)) |-> ((mask_q & ~len_cur) == '0));

  // R6: done is a single-cycle pulse followed by idle
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

endmodule

// File: rtl/mvx_unit.sv
module mvx_unit
  import mvx_pkg::*;
#(
  parameter int NELEM = 8,
  parameter int EW    = 16,
  parameter int NREG  = 4,
  localparam int RW   = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int IW   = (NELEM > 1) ? $clog2(NELEM) : 1,
  localparam int LW   = $clog2(NELEM + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic             cmd_dense,
  input  logic [LW-1:0]    cmd_vlen,
  input  logic [RW-1:0]    cmd_src_a,
  input  logic [RW-1:0]    cmd_src_b,
  input  logic [RW-1:0]    cmd_dst,
  output logic             busy,
  output logic             done,
  output logic [RW-1:0]    rd_reg_a,
  output logic [RW-1:0]    rd_reg_b,
  output logic [IW-1:0]    rd_elem,
  input  logic [EW-1:0]    rd_data_a,
  input  logic [EW-1:0]    rd_data_b,
  output logic             wr_en,
  output logic [RW-1:0]    wr_reg,
  output logic [IW-1:0]    wr_elem,
  output logic [EW-1:0]    wr_data,
  output logic [NELEM-1:0] vmask
);

  mvx_op_e       op_q;
  logic [RW-1:0] src_a_q, src_b_q, dst_q;
  logic [IW-1:0] idx_q;
  logic          cmp_bit;

  mvx_seq #(.N(NELEM), .RW(RW), .LW(LW), .IW(IW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_dense (cmd_dense),
    .cmd_vlen  (cmd_vlen),
    .cmd_src_a (cmd_src_a),
    .cmd_src_b (cmd_src_b),
    .cmd_dst   (cmd_dst),
    .cmp_bit   (cmp_bit),
    .op_q      (op_q),
    .src_a_q   (src_a_q),
    .src_b_q   (src_b_q),
    .dst_q     (dst_q),
    .idx_q     (idx_q),
    .mask_q    (vmask),
    .wr_en     (wr_en),
    .busy      (busy),
    .done      (done)
  );

  mvx_alu #(.EW(EW)) u_alu (
    .op      (op_q),
    .a       (rd_data_a),
    .b       (rd_data_b),
    .res     (wr_data),
    .cmp_bit (cmp_bit)
  );

  assign rd_reg_a = src_a_q;
  assign rd_reg_b = src_b_q;
  assign rd_elem  = idx_q;
  assign wr_reg   = dst_q;
  assign wr_elem  = idx_q;

endmodule

// File: tb/mvx_unit_tb.sv
`timescale 1ns/1ps
module mvx_unit_tb;

  localparam int N  = 8;
  localparam int EW = 16;
  localparam int NR = 4;
  localparam int RW = 2;
  localparam int IW = 3;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = 3'd7;
  logic          cmd_dense = 1'b0;
  logic [LW-1:0] cmd_vlen = '0;
  logic [RW-1:0] cmd_src_a = '0, cmd_src_b = '0, cmd_dst = '0;
  logic          busy, done, wr_en;
  logic [RW-1:0] rd_reg_a, rd_reg_b, wr_reg;
  logic [IW-1:0] rd_elem, wr_elem;
  logic [EW-1:0] rd_data_a, rd_data_b, wr_data;
  logic [N-1:0]  vmask;

  logic [EW-1:0] vrf  [NR][N];
  logic [EW-1:0] emod [NR][N];
  logic [N-1:0]  emask;
  int            wlog [N];
  int            wcnt;
  logic          tb_we = 1'b0, tb_clr = 1'b0;
  logic [RW-1:0] tb_reg = '0;
  logic [IW-1:0] tb_elem = '0;
  logic [EW-1:0] tb_data = '0;
  int            nvec = 0, nbad = 0;
  bit            finished = 1'b0;

  always #4 clk = ~clk;

  mvx_unit #(.NELEM(N), .EW(EW), .NREG(NR)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_dense(cmd_dense), .cmd_vlen(cmd_vlen), .cmd_src_a(cmd_src_a),
    .cmd_src_b(cmd_src_b), .cmd_dst(cmd_dst), .busy(busy), .done(done),
    .rd_reg_a(rd_reg_a), .rd_reg_b(rd_reg_b), .rd_elem(rd_elem),
    .rd_data_a(rd_data_a), .rd_data_b(rd_data_b), .wr_en(wr_en),
    .wr_reg(wr_reg), .wr_elem(wr_elem), .wr_data(wr_data), .vmask(vmask)
  );

  assign rd_data_a = vrf[rd_reg_a][rd_elem];
  assign rd_data_b = vrf[rd_reg_b][rd_elem];

  always @(posedge clk) begin
    if (tb_clr) wcnt <= 0;
    if (wr_en) begin
      vrf[wr_reg][wr_elem] <= wr_data;
      if (!tb_clr && wcnt < N) begin
        wlog[wcnt] <= int'(wr_elem);
        wcnt <= wcnt + 1;
      end
    end else if (tb_we) begin
      vrf[tb_reg][tb_elem] <= tb_data;
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic load_reg(input int r, input logic [EW-1:0] v [N]);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      tb_we = 1'b1; tb_reg = RW'(r); tb_elem = IW'(i); tb_data = v[i];
      emod[r][i] = v[i];
    end
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  function automatic int popc(input logic [N-1:0] m, input int vlen);
    int c = 0;
    for (int i = 0; i < N; i++) if (i < vlen && m[i]) c++;
    return c;
  endfunction

  // Issues one command and returns the number of cycles busy was sampled high.
  task automatic issue(input int op, input bit dense, input int vlen, input int a, input int b,
                       input int d, input bit poke, output int cyc);
    int guard = 0;
    @(negedge clk);
    tb_clr = 1'b1;
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_dense = dense; cmd_vlen = LW'(vlen);
    cmd_src_a = RW'(a); cmd_src_b = RW'(b); cmd_dst = RW'(d);
    @(posedge clk);
    cyc = 0;
    forever begin
      @(negedge clk);
      tb_clr = 1'b0;
      if (guard == 0 && poke) begin
        cmd_valid = 1'b1; cmd_op = 3'd6; cmd_vlen = LW'(N);
      end else begin
        cmd_valid = 1'b0;
      end
      if (busy) cyc++;
      guard++;
      if (done) break;
      if (guard > 64) begin
        chk("R6", "watchdog on done", 64'(guard), 64'd0);
        break;
      end
    end
    cmd_valid = 1'b0;
  endtask

  // Runs one command, updates the reference model and checks cycles, mask and registers.
  task automatic do_op(input string req, input int op, input bit dense, input int vlen,
                       input int a, input int b, input int d, input bit poke);
    int cyc, expc, pc;
    int order [N];
    int k;
    pc = popc(emask, vlen);
    if (op >= 3 && op <= 5) expc = vlen + 1;
    else if (op >= 6) expc = 1;
    else expc = dense ? pc + 1 : vlen + 1;
    k = 0;
    for (int i = 0; i < N; i++) if (i < vlen && emask[i]) begin order[k] = i; k++; end
    issue(op, dense, vlen, a, b, d, poke, cyc);
    case (op)
      0, 1, 2: begin
        for (int i = 0; i < N; i++) begin
          if (i < vlen && emask[i]) begin
            if (op == 0) emod[d][i] = emod[a][i] + emod[b][i];
            else if (op == 1) emod[d][i] = emod[a][i] - emod[b][i];
            else emod[d][i] = emod[a][i];
          end
        end
      end
      3, 4, 5: begin
        for (int i = 0; i < N; i++) begin
          if (i >= vlen) emask[i] = 1'b0;
          else if (op == 3) emask[i] = (emod[a][i] == '0);
          else if (op == 4) emask[i] = (emod[a][i] != '0);
          else emask[i] = (emod[a][i] >= emod[b][i]);
        end
      end
      6: for (int i = 0; i < N; i++) emask[i] = (i < vlen) ? ~emask[i] : 1'b0;
      default: ;
    endcase
    chk(req, "busy cycles", 64'(cyc), 64'(expc));
    chk(req, "vmask", 64'(vmask), 64'(emask));
    for (int r = 0; r < NR; r++)
      for (int i = 0; i < N; i++)
        chk(req, $sformatf("reg%0d[%0d]", r, i), 64'(vrf[r][i]), 64'(emod[r][i]));
    if (op <= 2) begin
      chk(req, "write count", 64'(wcnt), 64'(pc));
      if (dense) for (int j = 0; j < pc && j < N; j++)
        chk(req, $sformatf("visit %0d", j), 64'(wlog[j]), 64'(order[j]));
    end
  endtask

  task automatic t_reset();
    chk("R1", "busy", 64'(busy), 64'd0);
    chk("R1", "done", 64'(done), 64'd0);
    chk("R1", "wr_en", 64'(wr_en), 64'd0);
    chk("R1", "vmask", 64'(vmask), 64'd0);
  endtask

  task automatic t_load();
    logic [EW-1:0] v0 [N] = '{16'h0000, 16'h0005, 16'h0000, 16'h0007, 16'hFFFF, 16'h0000, 16'h0003, 16'h0009};
    logic [EW-1:0] v1 [N] = '{16'h0000, 16'h0006, 16'h0001, 16'h0007, 16'h0002, 16'h8000, 16'h0003, 16'h0001};
    logic [EW-1:0] v2 [N] = '{16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'h5555, 16'h6666, 16'h7777, 16'h8888};
    logic [EW-1:0] v3 [N] = '{16'hAAAA, 16'hAAAA, 16'hAAAA, 16'hAAAA, 16'hAAAA, 16'hAAAA, 16'hAAAA, 16'hAAAA};
    load_reg(0, v0); load_reg(1, v1); load_reg(2, v2); load_reg(3, v3);
  endtask

  task automatic t_compare();
    do_op("R3", 3, 1'b0, 8, 0, 1, 0, 1'b0);
    do_op("R3", 4, 1'b0, 5, 0, 1, 0, 1'b0);
    do_op("R3", 5, 1'b0, 8, 0, 1, 0, 1'b0);
    do_op("R3", 5, 1'b0, 3, 1, 0, 0, 1'b0);
  endtask

  task automatic t_complement();
    do_op("R4", 4, 1'b0, 8, 0, 1, 0, 1'b0);
    do_op("R4", 6, 1'b0, 6, 0, 0, 0, 1'b0);
    do_op("R4", 6, 1'b0, 8, 0, 0, 0, 1'b0);
  endtask

  task automatic t_simple();
    do_op("R5", 4, 1'b0, 8, 0, 1, 0, 1'b0);
    do_op("R6", 0, 1'b0, 8, 0, 1, 2, 1'b0);
    do_op("R5", 1, 1'b0, 7, 2, 1, 3, 1'b0);
    do_op("R6", 2, 1'b0, 4, 1, 0, 2, 1'b0);
  endtask

  task automatic t_dense();
    do_op("R7", 4, 1'b0, 8, 1, 0, 0, 1'b0);
    do_op("R7", 0, 1'b1, 8, 0, 1, 3, 1'b0);
    do_op("R7", 1, 1'b1, 6, 3, 0, 2, 1'b0);
    do_op("R7", 3, 1'b0, 8, 2, 0, 0, 1'b0);
    do_op("R7", 2, 1'b1, 8, 1, 0, 3, 1'b0);
  endtask

  task automatic t_cmp_dense();
    do_op("R8", 5, 1'b1, 8, 0, 1, 0, 1'b0);
    do_op("R8", 4, 1'b1, 2, 1, 0, 0, 1'b0);
  endtask

  task automatic t_len0();
    do_op("R9", 4, 1'b0, 8, 1, 0, 0, 1'b0);
    do_op("R9", 0, 1'b0, 0, 0, 1, 2, 1'b0);
    do_op("R9", 0, 1'b1, 0, 0, 1, 2, 1'b0);
    do_op("R9", 3, 1'b0, 0, 0, 1, 0, 1'b0);
  endtask

  task automatic t_select();
    do_op("R10", 5, 1'b0, 8, 0, 1, 0, 1'b0);
    do_op("R10", 2, 1'b0, 8, 0, 0, 3, 1'b0);
    do_op("R10", 6, 1'b0, 8, 0, 0, 0, 1'b0);
    do_op("R10", 2, 1'b1, 8, 1, 0, 3, 1'b0);
    for (int i = 0; i < N; i++) begin
      logic [EW-1:0] mx;
      mx = (emod[0][i] >= emod[1][i]) ? emod[0][i] : emod[1][i];
      chk("R10", $sformatf("max[%0d]", i), 64'(vrf[3][i]), 64'(mx));
    end
  endtask

  task automatic t_busy_ignore();
    do_op("R2", 4, 1'b0, 8, 0, 1, 0, 1'b0);
    do_op("R2", 0, 1'b0, 8, 0, 1, 2, 1'b1);
    do_op("R2", 7, 1'b0, 8, 0, 1, 2, 1'b0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      nvec++; nbad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    emask = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_compare();
    t_complement();
    t_simple();
    t_dense();
    t_cmp_dense();
    t_len0();
    t_select();
    t_busy_ignore();
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule